// File: doc/BRIEF.md
# Instant-Clear Synchronous RAM

This block is a single-port-per-direction synchronous RAM (one write port, one read port) that acts as if every word were wiped to zero the moment reset is applied. The storage array is never touched by reset. Instead, a flop-based presence vector holds one bit per word. Reset clears the whole vector in a single cycle. Any read of a word whose presence bit is clear comes back as zero, whatever the array happens to hold.

The presence vector and the array are looked up in the same clock edge. The masking therefore costs no extra cycle. Reads have a one-cycle latency, and the read port holds its last result while no read is requested. Depth and data width are parameters, and the address width is derived from the depth. When the depth is not a power of two, addresses past the last word are harmless: writes to them are dropped and reads from them give zero.

Top module: `vmem_top`

## Requirements
- R1: After reset, a read of any word that has not been written since that reset returns all zeros.
- R2: Reset clears every word in one cycle. A word written before reset reads zero after it, and `rd_data` itself is zero in the cycle after a reset edge.
- R3: A read has one cycle of latency. The data for a read sampled at a rising edge is on `rd_data` just after that edge, and the value present before that edge is the previous result.
- R4: A write stores `wr_data` at `wr_addr`. A later read of that address returns the stored value until the word is written again or reset occurs.
- R5: When a read and a write hit the same address in the same cycle, the read returns the contents from before the write. That is zero if the word was not yet valid. A following read returns the new data.
- R6: When reset and a write fall in the same cycle, reset wins. The written word stays invalid and reads zero afterwards.
- R7: While `rd_en` is low and reset is low, `rd_data` keeps its previous value, even if writes change the word last read.
- R8: Addresses at or above DEPTH are out of range. Writes to them change no word, including any word the address would alias onto. Reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; invalidates all words |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write word address |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_data | output | WIDTH | Read result, one cycle after the request; zero for invalid words |

## Verification
The bench builds the block with DEPTH=12 and WIDTH=8. The address is then 4 bits wide, and codes 12 to 15 are reachable but lie outside the array. This exercises the out-of-range write drop, the zero read, and the absence of aliasing onto low words, which a power-of-two depth cannot reach. A depth of 12 is also small enough that every word is written, read back, reset and read again within one short run. The same-cycle read/write and reset/write collisions are driven on words with known earlier contents, so a design that returned stale array data instead of masking it would be seen.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  // True when a word address lies inside the populated part of the array.
  function automatic logic in_span(input int unsigned addr, input int unsigned depth);
    return addr < depth;
  endfunction

endpackage

// File: rtl/vmem_array.sv
module vmem_array #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] q
);
  import vmem_pkg::*;

  // Plain array without reset so that block RAM can be inferred.
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we && in_span(32'(wa), DEPTH)) store[wa] <= wd;
  end

  // Registered read: old contents on a same-address collision.
  always_ff @(posedge clk) begin
    if (re && in_span(32'(ra), DEPTH)) q <= store[ra];
  end
endmodule

// File: rtl/vmem_valid.sv
module vmem_valid #(
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic          hit_q
);
  import vmem_pkg::*;

  logic [DEPTH-1:0] present;

  always_ff @(posedge clk) begin
    if (rst) begin
      present <= '0;
    end else if (we && in_span(32'(wa), DEPTH)) begin
      present[wa] <= 1'b1;
    end
  end

  // Sampled on the same edge as the array read, so the flag and the
  // data belong to the same address.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else if (re) begin
      hit_q <= in_span(32'(ra), DEPTH) ? present[ra] : 1'b0;
    end
  end
endmodule

// File: rtl/vmem_mask.sv
module vmem_mask #(
  parameter int WIDTH = 8
) (
  input  logic             hit_q,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] data
);
  always_comb begin
    data = hit_q ? raw : '0;
  end
endmodule

// File: rtl/vmem_top.sv
module vmem_top #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic             wr_go;
  logic [WIDTH-1:0] raw_q;
  logic             hit_q;

  // Reset has priority over a write in the same cycle.
  assign wr_go = wr_en && !rst;

  vmem_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_array (
    .clk (clk),
    .we  (wr_go),
    .wa  (wr_addr),
    .wd  (wr_data),
    .re  (rd_en),
    .ra  (rd_addr),
    .q   (raw_q)
  );

  vmem_valid #(.DEPTH(DEPTH), .AW(AW)) u_valid (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .wa    (wr_addr),
    .re    (rd_en),
    .ra    (rd_addr),
    .hit_q (hit_q)
  );

  vmem_mask #(.WIDTH(WIDTH)) u_mask (
    .hit_q (hit_q),
    .raw   (raw_q),
    .data  (rd_data)
  );
endmodule

// File: rtl/vmem_chk.sv
module vmem_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data
);
  logic rd_in, wr_in;
  assign rd_in = 32'(rd_addr) < DEPTH;
  assign wr_in = 32'(wr_addr) < DEPTH;

  p_reset_zero_r2: assert property (@(posedge clk) rst |=> rd_data == '0);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_oob_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_in) |=> rd_data == '0);

  p_write_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_in && !$past(rst) && $past(wr_en) && rd_addr == $past(wr_addr))
    |=> rd_data == $past(wr_data, 2));

  p_reset_beats_write_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(wr_en) && rd_en && rd_addr == $past(wr_addr))
    |=> rd_data == '0);
endmodule

bind vmem_top vmem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_vmem_top.sv
module sim_vmem_top;
  localparam int DEPTH = 12;
  localparam int WIDTH = 8;
  localparam int AW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic [WIDTH-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  vmem_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (.*);

  task automatic check(input string req, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", req, got, exp);
    end
  endtask

  // One clock: drive inputs, take the edge, settle just after it.
  task automatic cyc(input logic r, input logic we, input logic [AW-1:0] wa,
                     input logic [WIDTH-1:0] wd, input logic re, input logic [AW-1:0] ra);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk); #1;
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    check("R2 reset output", rd_data, '0);
  endtask

  task automatic t_unwritten();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 0, 1, AW'(i));
      check("R1 unwritten word", rd_data, '0);
    end
  endtask

  task automatic t_fill_read();
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, AW'(i), 8'hA0 + 8'(i), 0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 0, 1, AW'(i));
      check("R4 readback", rd_data, 8'hA0 + 8'(i));
    end
  endtask

  task automatic t_latency();
    cyc(0, 0, 0, 0, 1, 3);
    check("R3 data after edge", rd_data, 8'hA3);
    rd_en = 1'b1; rd_addr = 5;
    #5;
    check("R3 before edge", rd_data, 8'hA3);
    @(posedge clk); #1;
    rd_en = 1'b0;
    check("R3 next read", rd_data, 8'hA5);
  endtask

  task automatic t_collision();
    cyc(0, 1, 2, 8'h5A, 1, 2);
    check("R5 collision on invalid word", rd_data, '0);
    cyc(0, 0, 0, 0, 1, 2);
    check("R5 after write", rd_data, 8'h5A);
    cyc(0, 1, 2, 8'h22, 1, 2);
    check("R5 collision returns old", rd_data, 8'h5A);
    cyc(0, 0, 0, 0, 1, 2);
    check("R5 new value", rd_data, 8'h22);
  endtask

  task automatic t_reset_clears();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 0, 1, AW'(i));
      check("R2 cleared word", rd_data, '0);
    end
  endtask

  task automatic t_reset_write();
    cyc(1, 1, 4, 8'h44, 0, 0);
    cyc(0, 0, 0, 0, 1, 4);
    check("R6 reset beats write", rd_data, '0);
  endtask

  task automatic t_hold();
    cyc(0, 1, 1, 8'h71, 0, 0);
    cyc(0, 0, 0, 0, 1, 1);
    check("R7 setup read", rd_data, 8'h71);
    cyc(0, 1, 1, 8'h99, 0, 6);
    check("R7 hold during write", rd_data, 8'h71);
    cyc(0, 0, 0, 0, 0, 0);
    check("R7 hold idle", rd_data, 8'h71);
  endtask

  task automatic t_oob();
    cyc(0, 1, 0, 8'h10, 0, 0);
    cyc(0, 1, 12, 8'hEE, 0, 0);
    cyc(0, 1, 15, 8'hEF, 0, 0);
    cyc(0, 0, 0, 0, 1, 12);
    check("R8 read addr 12", rd_data, '0);
    cyc(0, 0, 0, 0, 1, 15);
    check("R8 read addr 15", rd_data, '0);
    cyc(0, 0, 0, 0, 1, 0);
    check("R8 no alias on word 0", rd_data, 8'h10);
    cyc(0, 0, 0, 0, 1, 3);
    check("R8 no alias on word 3", rd_data, '0);
  endtask

  initial begin
    do_reset();
    t_unwritten();
    t_fill_read();
    t_latency();
    t_reset_clears();
    t_collision();
    t_reset_write();
    t_hold();
    t_oob();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule